// File: doc/BRIEF.md
# Multicycle 16-bit Processor Core

A small processor core that runs each instruction over several clock cycles and shares one memory port between instruction fetch and data access. It holds eight 16-bit general registers, a program counter, an instruction register, operand latches, a memory address latch and a single ALU. A finite state machine steps every instruction through fetch, decode and one or more execute states. In each state it sets the load enables, the multiplexer selects, the ALU operation and the memory strobes.

The memory sits outside the core and answers reads combinationally: read data for the address on the bus must be valid in the same cycle that the read strobe is high. Writes are taken at the rising clock edge while the write strobe is high. The program counter is incremented through the shared ALU during fetch, so there is no separate incrementer. Because of that sharing, loads, stores and taken branches each need an extra execute cycle.

Top module: `mc16_core`

## Requirements
- R1: While `rst_ni` is low, and in the first cycle after it rises, the core is in fetch with PC = 0: `mem_rd_o`=1, `mem_wr_o`=0, `mem_addr_o`=0 and `halted_o`=0. All eight registers read as zero after reset.
- R2: Every instruction starts with one fetch cycle (`mem_rd_o`=1, `mem_addr_o`=PC, IR loads `mem_rdata_i`, PC becomes PC+1). This is followed by one decode cycle with no memory strobe. Fields: opcode = bits 15:13, rs = 12:10, rt = 9:7, rd = 6:4, funct = 3:0, offset = 6:0 (sign-extended), target = 12:0.
- R3: Opcode 0 with funct 0/1/2/3 writes rs+rt, rs−rt, rs AND rt, rs OR rt to rd in a single execute cycle (3 cycles in total).
- R4: Opcode 0 with funct 4 writes 1 to rd if rs < rt as signed two's complement numbers, and 0 otherwise (3 cycles).
- R5: Opcode 4 writes rs+offset to rt (3 cycles).
- R6: Opcode 1 computes rs+offset in one cycle. In the next cycle it reads memory at that address and writes the data to rt (4 cycles).
- R7: Opcode 2 computes rs+offset in one cycle. In the next cycle it drives that address with `mem_wr_o`=1 and `mem_wdata_o`=rt (4 cycles). Read and write strobes are never high together.
- R8: Opcode 3 compares rs with rt through the ALU. If they differ, the instruction ends after 3 cycles. If they are equal, a fourth cycle sets PC to (address of the branch + 1) + offset.
- R9: Opcode 5 sets PC to the zero-extended target (3 cycles).
- R10: Opcode 7 raises `halted_o` from the cycle after its decode. The core then stays halted with no memory strobes until reset.
- R11: Opcode 6, and opcode 0 with funct 5 to 15, change nothing and go back to fetch after decode (2 cycles).
- R12: Register r0 is an ordinary register: it can be written and read back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mem_addr_o | output | 16 | Memory word address |
| mem_rd_o | output | 1 | Read strobe |
| mem_wr_o | output | 1 | Write strobe |
| mem_wdata_o | output | 16 | Write data |
| mem_rdata_i | input | 16 | Read data, valid in the same cycle as the read strobe |
| halted_o | output | 1 | Core stopped by a halt instruction |

## Verification
The assertions assume that the memory returns read data combinationally and that nothing but reset is needed to leave the halted state. The bench memory meets both: it is an array indexed directly by the address bus and written at the clock edge. The programs only touch the low 256 words and keep every offset within its 7-bit signed range. A behavioural model predicts the bus activity and the halt flag for every cycle from the instruction semantics and cycle counts, and this prediction is compared on each clock. This covers signed comparisons, forward branches and branches over skipped code, negative offsets, r0 as a destination, undefined encodings, and a reset applied while the core is halted.

// File: rtl/mc16_pkg.sv
package mc16_pkg;
  localparam int XLEN   = 16;
  localparam int NREG   = 8;
  localparam int RIDX_W = $clog2(NREG);
  localparam int IMM_W  = 7;
  localparam int TGT_W  = 13;

  localparam logic [2:0] OP_RR   = 3'd0;
  localparam logic [2:0] OP_LOAD = 3'd1;
  localparam logic [2:0] OP_STOR = 3'd2;
  localparam logic [2:0] OP_BEQ  = 3'd3;
  localparam logic [2:0] OP_ADDI = 3'd4;
  localparam logic [2:0] OP_JMP  = 3'd5;
  localparam logic [2:0] OP_HALT = 3'd7;
  localparam logic [3:0] FN_MAX  = 4'd4;

  typedef enum logic [3:0] {
    S_FETCH, S_DECODE, S_EXR, S_EXI, S_MADDR, S_LDRD, S_STWR,
    S_BRCMP, S_BRADD, S_JMP, S_HALT
  } st_e;

  typedef enum logic [2:0] {
    ALU_ADD = 3'd0, ALU_SUB = 3'd1, ALU_AND = 3'd2, ALU_OR = 3'd3, ALU_SLT = 3'd4
  } alu_op_e;

  typedef enum logic [1:0] {BSEL_REG, BSEL_ONE, BSEL_IMM} bsel_e;

  typedef struct packed {
    logic    ir_ld;
    logic    pc_ld;
    logic    pc_jmp;
    logic    ab_ld;
    logic    mar_ld;
    logic    rf_we;
    logic    rf_from_mem;
    logic    rf_to_rd;
    logic    a_pc;
    bsel_e   bsel;
    alu_op_e aop;
    logic    mem_rd;
    logic    mem_wr;
    logic    addr_mar;
  } ctrl_t;
endpackage

// File: rtl/mc16_alu.sv
module mc16_alu
  import mc16_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  alu_op_e      op_i,
  output logic [W-1:0] y_o,
  output logic         zero_o
);
  always_comb begin
    unique case (op_i)
      ALU_ADD: y_o = a_i + b_i;
      ALU_SUB: y_o = a_i - b_i;
      ALU_AND: y_o = a_i & b_i;
      ALU_OR:  y_o = a_i | b_i;
      ALU_SLT: y_o = {{(W-1){1'b0}}, ($signed(a_i) < $signed(b_i))};
      default: y_o = '0;
    endcase
  end
  assign zero_o = (y_o == '0);
endmodule

// File: rtl/mc16_regfile.sv
module mc16_regfile #(
  parameter int W = 16,
  parameter int N = 8,
  localparam int AW = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic [AW-1:0] raddr_a_i,
  input  logic [AW-1:0] raddr_b_i,
  output logic [W-1:0]  rdata_a_o,
  output logic [W-1:0]  rdata_b_o
);
  logic [W-1:0] regs [N];

  for (genvar i = 0; i < N; i++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              regs[i] <= '0;
      else if (we_i && waddr_i == AW'(i))       regs[i] <= wdata_i;
    end
  end

  assign rdata_a_o = regs[raddr_a_i];
  assign rdata_b_o = regs[raddr_b_i];
endmodule

// File: rtl/mc16_ctrl.sv
module mc16_ctrl
  import mc16_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [2:0] opcode_i,
  input  logic [3:0] funct_i,
  input  logic       zero_i,
  output st_e        st_o,
  output ctrl_t      c_o
);
  st_e st_q, st_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= S_FETCH;
    else         st_q <= st_d;
  end

  always_comb begin
    st_d = S_FETCH;
    unique case (st_q)
      S_DECODE: begin
        unique case (opcode_i)
          OP_RR:            st_d = (funct_i <= FN_MAX) ? S_EXR : S_FETCH;
          OP_LOAD, OP_STOR: st_d = S_MADDR;
          OP_BEQ:           st_d = S_BRCMP;
          OP_ADDI:          st_d = S_EXI;
          OP_JMP:           st_d = S_JMP;
          OP_HALT:          st_d = S_HALT;
          default:          st_d = S_FETCH;
        endcase
      end
      S_FETCH: st_d = S_DECODE;
      S_MADDR: st_d = (opcode_i == OP_LOAD) ? S_LDRD : S_STWR;
      S_BRCMP: st_d = zero_i ? S_BRADD : S_FETCH;
      S_HALT:  st_d = S_HALT;
      default: st_d = S_FETCH;
    endcase
  end

  always_comb begin
    c_o      = '0;
    c_o.bsel = BSEL_REG;
    c_o.aop  = ALU_ADD;
    unique case (st_q)
      S_FETCH: begin
        c_o.ir_ld = 1'b1; c_o.pc_ld = 1'b1; c_o.a_pc = 1'b1;
        c_o.bsel  = BSEL_ONE; c_o.mem_rd = 1'b1;
      end
      S_DECODE: c_o.ab_ld = 1'b1;
      S_EXR: begin
        c_o.rf_we = 1'b1; c_o.rf_to_rd = 1'b1;
        c_o.aop   = alu_op_e'(funct_i[2:0]);
      end
      S_EXI: begin
        c_o.rf_we = 1'b1; c_o.bsel = BSEL_IMM;
      end
      S_MADDR: begin
        c_o.mar_ld = 1'b1; c_o.bsel = BSEL_IMM;
      end
      S_LDRD: begin
        c_o.mem_rd = 1'b1; c_o.addr_mar = 1'b1;
        c_o.rf_we  = 1'b1; c_o.rf_from_mem = 1'b1;
      end
      S_STWR: begin
        c_o.mem_wr = 1'b1; c_o.addr_mar = 1'b1;
      end
      S_BRCMP: c_o.aop = ALU_SUB;
      S_BRADD: begin
        c_o.a_pc = 1'b1; c_o.bsel = BSEL_IMM; c_o.pc_ld = 1'b1;
      end
      S_JMP: begin
        c_o.pc_ld = 1'b1; c_o.pc_jmp = 1'b1;
      end
      default: ;
    endcase
  end

  assign st_o = st_q;
endmodule

// File: rtl/mc16_core.sv
module mc16_core
  import mc16_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  output logic [XLEN-1:0] mem_addr_o,
  output logic            mem_rd_o,
  output logic            mem_wr_o,
  output logic [XLEN-1:0] mem_wdata_o,
  input  logic [XLEN-1:0] mem_rdata_i,
  output logic            halted_o
);
  logic [XLEN-1:0] ir_q, pc_q, a_q, b_q, mar_q;
  logic [XLEN-1:0] rf_a, rf_b, alu_a, alu_b, alu_y, imm_sx, tgt_zx, rf_wdata;
  logic [RIDX_W-1:0] rs, rt, rd, rf_waddr;
  logic  alu_zero;
  ctrl_t c;
  st_e   st;

  assign rs     = ir_q[12:10];
  assign rt     = ir_q[9:7];
  assign rd     = ir_q[6:4];
  assign imm_sx = {{(XLEN-IMM_W){ir_q[IMM_W-1]}}, ir_q[IMM_W-1:0]};
  assign tgt_zx = {{(XLEN-TGT_W){1'b0}}, ir_q[TGT_W-1:0]};

  mc16_ctrl u_ctrl (
    .clk_i, .rst_ni,
    .opcode_i(ir_q[15:13]), .funct_i(ir_q[3:0]), .zero_i(alu_zero),
    .st_o(st), .c_o(c)
  );

  assign rf_waddr = c.rf_to_rd ? rd : rt;
  assign rf_wdata = c.rf_from_mem ? mem_rdata_i : alu_y;

  mc16_regfile #(.W(XLEN), .N(NREG)) u_rf (
    .clk_i, .rst_ni,
    .we_i(c.rf_we), .waddr_i(rf_waddr), .wdata_i(rf_wdata),
    .raddr_a_i(rs), .raddr_b_i(rt), .rdata_a_o(rf_a), .rdata_b_o(rf_b)
  );

  assign alu_a = c.a_pc ? pc_q : a_q;
  always_comb begin
    unique case (c.bsel)
      BSEL_ONE: alu_b = XLEN'(1);
      BSEL_IMM: alu_b = imm_sx;
      default:  alu_b = b_q;
    endcase
  end

  mc16_alu #(.W(XLEN)) u_alu (
    .a_i(alu_a), .b_i(alu_b), .op_i(c.aop), .y_o(alu_y), .zero_o(alu_zero)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ir_q <= '0; pc_q <= '0; a_q <= '0; b_q <= '0; mar_q <= '0;
    end else begin
      if (c.ir_ld)  ir_q  <= mem_rdata_i;
      if (c.pc_ld)  pc_q  <= c.pc_jmp ? tgt_zx : alu_y;
      if (c.ab_ld)  begin a_q <= rf_a; b_q <= rf_b; end
      if (c.mar_ld) mar_q <= alu_y;
    end
  end

  assign mem_addr_o  = c.addr_mar ? mar_q : pc_q;
  assign mem_rd_o    = c.mem_rd;
  assign mem_wr_o    = c.mem_wr;
  assign mem_wdata_o = b_q;
  assign halted_o    = (st == S_HALT);
endmodule

// File: rtl/mc16_core_chk.sv
module mc16_core_chk
  import mc16_pkg::*;
(
  input logic            clk_i,
  input logic            rst_ni,
  input logic            mem_rd_o,
  input logic            mem_wr_o,
  input logic            halted_o,
  input st_e             st,
  input logic [XLEN-1:0] pc
);
  assert_halt_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |=> halted_o);

  assert_halt_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |-> !(mem_rd_o || mem_wr_o));

  assert_no_rd_wr_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_rd_o && mem_wr_o));

  assert_store_then_fetch_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_wr_o |=> (mem_rd_o && !mem_wr_o));

  assert_fetch_incr_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == S_FETCH) |=> (pc == $past(pc) + 16'd1));

  assert_fetch_decode_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == S_FETCH) |=> (st == S_DECODE));
endmodule

bind mc16_core mc16_core_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .mem_rd_o(mem_rd_o), .mem_wr_o(mem_wr_o),
  .halted_o(halted_o), .st(st), .pc(pc_q)
);

// File: tb/mc16_core_tb.sv
module mc16_core_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [15:0] mem_addr, mem_wdata, mem_rdata;
  logic        mem_rd, mem_wr, halted;

  mc16_core u_dut (
    .clk_i(clk), .rst_ni(rst_n), .mem_addr_o(mem_addr), .mem_rd_o(mem_rd),
    .mem_wr_o(mem_wr), .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
    .halted_o(halted)
  );

  logic [15:0] dmem [256];
  assign mem_rdata = dmem[mem_addr[7:0]];
  always @(posedge clk) if (mem_wr) dmem[mem_addr[7:0]] <= mem_wdata;

  int tests = 0, fails = 0;

  // behavioural reference
  logic [15:0] mmem [256];
  logic [15:0] mreg [8];
  logic [15:0] mpc;
  bit          mhalt;
  bit          q_rd[$], q_wr[$], q_h[$];
  logic [15:0] q_a[$], q_wd[$];
  string       q_t[$];

  task automatic push(bit rd, bit wr, logic [15:0] a, logic [15:0] wd, bit h, string t);
    q_rd.push_back(rd); q_wr.push_back(wr); q_a.push_back(a);
    q_wd.push_back(wd); q_h.push_back(h); q_t.push_back(t);
  endtask

  function automatic logic [15:0] sx7(logic [6:0] v);
    return {{9{v[6]}}, v};
  endfunction

  task automatic model_step();
    logic [15:0] ir, a, b, off, ea, res;
    logic [2:0] op;
    logic [3:0] fn;
    if (mhalt) begin push(0, 0, 0, 0, 1, "R10"); return; end
    ir = mmem[mpc[7:0]];
    push(1, 0, mpc, 0, 0, "R2");
    mpc = mpc + 16'd1;
    push(0, 0, 0, 0, 0, "R2");
    op = ir[15:13]; fn = ir[3:0];
    a = mreg[ir[12:10]]; b = mreg[ir[9:7]]; off = sx7(ir[6:0]);
    ea = a + off;
    case (op)
      3'd0: if (fn <= 4'd4) begin
        case (fn)
          4'd0: res = a + b;
          4'd1: res = a - b;
          4'd2: res = a & b;
          4'd3: res = a | b;
          default: res = ($signed(a) < $signed(b)) ? 16'd1 : 16'd0;
        endcase
        push(0, 0, 0, 0, 0, (fn == 4'd4) ? "R4" : "R3");
        mreg[ir[6:4]] = res;
      end
      3'd1: begin
        push(0, 0, 0, 0, 0, "R6"); push(1, 0, ea, 0, 0, "R6");
        mreg[ir[9:7]] = mmem[ea[7:0]];
      end
      3'd2: begin
        push(0, 0, 0, 0, 0, "R7"); push(0, 1, ea, b, 0, "R7");
        mmem[ea[7:0]] = b;
      end
      3'd3: begin
        push(0, 0, 0, 0, 0, "R8");
        if (a == b) begin push(0, 0, 0, 0, 0, "R8"); mpc = mpc + off; end
      end
      3'd4: begin push(0, 0, 0, 0, 0, "R5"); mreg[ir[9:7]] = ea; end
      3'd5: begin push(0, 0, 0, 0, 0, "R9"); mpc = {3'b0, ir[12:0]}; end
      3'd7: mhalt = 1'b1;
      default: ; // R11: undefined opcode, nothing further
    endcase
  endtask

  function automatic logic [15:0] rr(int fn, int rs, int rt, int rd);
    return {3'd0, 3'(rs), 3'(rt), 3'(rd), 4'(fn)};
  endfunction
  function automatic logic [15:0] ii(int op, int rs, int rt, int off);
    return {3'(op), 3'(rs), 3'(rt), 7'(off)};
  endfunction
  function automatic logic [15:0] jj(int t);
    return {3'd5, 13'(t)};
  endfunction

  task automatic put(int adr, logic [15:0] w);
    dmem[adr] = w; mmem[adr] = w;
  endtask

  task automatic clear_all();
    for (int i = 0; i < 256; i++) begin dmem[i] = '0; mmem[i] = '0; end
  endtask

  task automatic check(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic run_prog(int max_cycles);
    int halt_seen;
    for (int i = 0; i < 8; i++) mreg[i] = '0;
    mpc = '0; mhalt = 1'b0;
    q_rd.delete(); q_wr.delete(); q_a.delete(); q_wd.delete(); q_h.delete(); q_t.delete();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    // R1: reset state
    check(mem_rd && !mem_wr && mem_addr == 16'd0 && !halted, "R1", "reset rd/wr/addr/halt",
          {mem_rd, mem_wr, halted, mem_addr}, {3'b100, 16'd0});
    rst_n = 1'b1;
    halt_seen = 0;
    for (int cyc = 0; cyc < max_cycles && halt_seen < 10; cyc++) begin
      bit e_rd, e_wr, e_h;
      logic [15:0] e_a, e_wd;
      string t;
      if (q_rd.size() == 0) model_step();
      e_rd = q_rd.pop_front(); e_wr = q_wr.pop_front(); e_a = q_a.pop_front();
      e_wd = q_wd.pop_front(); e_h = q_h.pop_front(); t = q_t.pop_front();
      check(mem_rd == e_rd && mem_wr == e_wr && halted == e_h, t, "strobes rd/wr/halt",
            {mem_rd, mem_wr, halted}, {e_rd, e_wr, e_h});
      if (e_rd || e_wr) check(mem_addr == e_a, t, "address", mem_addr, e_a);
      if (e_wr) check(mem_wdata == e_wd, t, "write data", mem_wdata, e_wd);
      if (e_h) halt_seen++;
      @(negedge clk);
    end
    check(halt_seen == 10, "R10", "halt reached", halt_seen, 10);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    // program 1: ALU ops, memory, branches, jump, undefined encodings, r0 writes
    clear_all();
    put(0,  ii(4, 0, 1, 5));
    put(1,  ii(4, 0, 2, -3));
    put(2,  rr(0, 1, 2, 3));
    put(3,  rr(1, 1, 2, 4));
    put(4,  rr(2, 1, 2, 5));
    put(5,  rr(3, 1, 2, 6));
    put(6,  rr(4, 2, 1, 7));
    put(7,  rr(4, 1, 2, 0));
    put(8,  ii(2, 0, 4, 40));
    put(9,  ii(1, 0, 0, 40));
    put(10, ii(3, 0, 4, 2));
    put(11, ii(4, 1, 1, 1));
    put(12, ii(4, 1, 1, 1));
    put(13, ii(3, 1, 2, 5));
    put(14, 16'hC000);
    put(15, rr(9, 1, 1, 1));
    put(16, jj(20));
    for (int i = 17; i < 20; i++) put(i, ii(4, 1, 1, 1));
    put(20, ii(4, 3, 3, -1));
    put(21, ii(3, 3, 7, 1));
    put(22, jj(20));
    put(23, ii(2, 1, 6, 36));
    put(24, ii(2, 1, 0, 37));
    put(25, 16'hE000);
    run_prog(400);
    check(dmem[40] == 16'd8,     "R7",  "mem[40]", dmem[40], 16'd8);
    check(dmem[41] == 16'hFFFD,  "R3",  "mem[41]", dmem[41], 16'hFFFD);
    check(dmem[42] == 16'd8,     "R12", "mem[42]", dmem[42], 16'd8);
    check(dmem[42] == mmem[42] && dmem[41] == mmem[41], "R11", "model memory agrees",
          {dmem[42], dmem[41]}, {mmem[42], mmem[41]});

    // program 2: reset from halt, negative offsets, signed compare
    clear_all();
    put(0, ii(4, 0, 1, 50));
    put(1, ii(2, 1, 1, -2));
    put(2, ii(1, 1, 2, -2));
    put(3, ii(2, 1, 2, -1));
    put(4, rr(1, 0, 1, 3));
    put(5, rr(4, 3, 0, 4));
    put(6, rr(4, 0, 3, 5));
    put(7, ii(2, 1, 4, -3));
    put(8, ii(2, 1, 5, -4));
    put(9, 16'hE000);
    run_prog(400);
    check(dmem[48] == 16'd50, "R7", "mem[48]", dmem[48], 16'd50);
    check(dmem[49] == 16'd50, "R6", "mem[49]", dmem[49], 16'd50);
    check(dmem[47] == 16'd1,  "R4", "mem[47]", dmem[47], 16'd1);
    check(dmem[46] == 16'd0,  "R4", "mem[46]", dmem[46], 16'd0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule